// File: doc/BRIEF.md
# I2C Clock Phase Timing Generator

This block paces an I2C master's clock line. A system clock first passes through a small programmable divider that produces the internal clock. A period counter running on that internal clock then splits each bus clock period into a low phase and a high phase. The block marks three points in every period with one-cycle ticks: the falling clock edge, the moment in the low phase where the data line may change, and the rising clock edge. It also drives a registered copy of the clock level. The protocol engine that consumes the ticks sits outside this block, and so does any choice of configuration values.

The period is a fixed base of 20 internal clocks, plus 8 internal clocks per step of the period field, plus a compensation term. The compensation term is fixed at elaboration from the nominal internal clock rate and the channel index. It covers the line's fall time, its rise time and an on-chip delay. A configuration written while the generator runs takes effect only when the current period ends, so no period is ever cut short or stretched by a write. All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `scl_timing_gen`

## Requirements
- R1: `timing_cfg[2:0]` is the divider select `cdf` and `timing_cfg[8:3]` is the period step count `scgd`.
- R2: While enabled, one internal clock lasts `cdf`+1 system clocks.
- R3: With an unchanged configuration, consecutive `tick_fall` pulses are P×(`cdf`+1) system clocks apart, where P = 20 + 8×`scgd` + F.
- R4: F is the ceiling of (35 ns + 200 ns + d) × `ICLK_HZ` / 1e9 internal clocks. d is 50 ns when `CHANNEL` is 0 and 5 ns for any other channel.
- R5: `tick_rise` follows `tick_fall` by ceil(P/2) internal clocks. The high phase takes the remainder of the period.
- R6: `tick_sda` follows `tick_fall` by floor(ceil(P/2)/2) internal clocks, while `scl_out` is low.
- R7: `scl_out` is low from the cycle after `tick_fall` and high from the cycle after `tick_rise`. It is high during reset and in the cycle after any cycle with `enable` low.
- R8: While `enable` is low, no tick is emitted and both counters are cleared. After `enable` rises, the first `tick_fall` comes after exactly `cdf` rising clock edges.
- R9: A configuration that changes during a period is adopted on the internal clock that ends that period. The old period completes unchanged, and the next internal clock and period use the new values.
- R10: At most one of `tick_fall`, `tick_sda` and `tick_rise` is high in any cycle.
- R11: A channel other than 0 uses the shorter delay. At the default internal clock of 16 MHz this gives 24 internal clocks per period with `scgd` = 0, against 25 for channel 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator; low holds it idle and cleared |
| timing_cfg | input | 9 | Divider select in bits 2:0, period steps in bits 8:3 |
| tick_fall | output | 1 | One-cycle pulse at the falling clock edge point |
| tick_sda | output | 1 | One-cycle pulse at the mid-low data change point |
| tick_rise | output | 1 | One-cycle pulse at the rising clock edge point |
| scl_out | output | 1 | Registered clock level, high when idle |

## Verification
The bench builds two copies of the block at `ICLK_HZ` = 16 MHz: one with `CHANNEL` = 0 (F = 5) and one with `CHANNEL` = 1 (F = 4). The channel 0 copy is driven across the extremes of both fields. These include the shortest period (`cdf` 0, `scgd` 0, 25 system clocks) and the longest (`cdf` 7, `scgd` 63, 4232 system clocks). The channel 0 copy is also given mid-period configuration changes in both directions of the divider. The second copy isolates the channel-dependent compensation term, which differs by one internal clock between the two builds.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  localparam int unsigned BASE_CLKS    = 20;
  localparam int unsigned STEP_SHIFT   = 3;
  localparam int unsigned FALL_NS      = 35;
  localparam int unsigned RISE_NS      = 200;
  localparam int unsigned DLY_CH0_NS   = 50;
  localparam int unsigned DLY_OTHER_NS = 5;

  // Compensation term in internal clocks, rounded up (R4).
  function automatic int unsigned edge_comp_clks(longint unsigned iclk_hz, int unsigned chan);
    longint unsigned span_ns;
    longint unsigned clks;
    span_ns = longint'(FALL_NS + RISE_NS + ((chan == 0) ? DLY_CH0_NS : DLY_OTHER_NS));
    clks = (span_ns * iclk_hz + 64'd999_999_999) / 64'd1_000_000_000;
    return 32'(clks);
  endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
module scl_cfg_hold #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] cfg_in,
  output logic [W-1:0] cfg_q
);

  // Follows the input while idle; while running, adopts it only at period end (R9).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (!run || load)
      cfg_q <= cfg_in;
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] div_sel,
  output logic             iclk_en
);

  logic [PRE_W-1:0] pcnt;

  assign iclk_en = run && (pcnt == div_sel);

  // R2: one enable every div_sel+1 system clocks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (!run || iclk_en)
      pcnt <= '0;
    else
      pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/scl_period_counter.sv
module scl_period_counter #(
  parameter int unsigned PER_W  = 6,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned F_CLKS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [PER_W-1:0] scgd,
  output logic [CNT_W-1:0] pos,
  output logic             at_last,
  output logic [CNT_W-1:0] low_len,
  output logic [CNT_W-1:0] sda_pos
);

  import scl_tg_pkg::*;

  logic [CNT_W-1:0] per_len;
  logic [CNT_W:0]   per_up;

  // R3: base + 8 per step + compensation.
  assign per_len = CNT_W'(BASE_CLKS + F_CLKS) + (CNT_W'(scgd) << STEP_SHIFT);
  assign per_up  = {1'b0, per_len} + 1'b1;
  assign low_len = per_up[CNT_W:1];
  assign sda_pos = low_len >> 1;
  assign at_last = (pos == per_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (!run)
      pos <= '0;
    else if (step)
      pos <= at_last ? '0 : pos + 1'b1;
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter longint unsigned ICLK_HZ = 16_000_000,
  parameter int unsigned     CHANNEL = 0,
  parameter int unsigned     PRE_W   = 3,
  parameter int unsigned     PER_W   = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [PRE_W+PER_W-1:0] timing_cfg,
  output logic                   tick_fall,
  output logic                   tick_sda,
  output logic                   tick_rise,
  output logic                   scl_out
);

  import scl_tg_pkg::*;

  localparam int unsigned CFG_W      = PRE_W + PER_W;
  localparam int unsigned F_CLKS     = edge_comp_clks(ICLK_HZ, CHANNEL);
  localparam int unsigned MAX_PERIOD = BASE_CLKS + ((2**PER_W) - 1) * (2**STEP_SHIFT) + F_CLKS;
  localparam int unsigned CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [CFG_W-1:0] act_cfg;
  logic             iclk_en;
  logic [CNT_W-1:0] pos;
  logic             at_last;
  logic [CNT_W-1:0] low_len;
  logic [CNT_W-1:0] sda_pos;
  logic             period_end;

  assign period_end = iclk_en && at_last;

  scl_cfg_hold #(.W(CFG_W)) i_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (enable),
    .load   (period_end),
    .cfg_in (timing_cfg),
    .cfg_q  (act_cfg)
  );

  // R1: divider select in the low field, period steps above it.
  scl_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .div_sel (act_cfg[PRE_W-1:0]),
    .iclk_en (iclk_en)
  );

  scl_period_counter #(.PER_W(PER_W), .CNT_W(CNT_W), .F_CLKS(F_CLKS)) i_per (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .step    (iclk_en),
    .scgd    (act_cfg[CFG_W-1:PRE_W]),
    .pos     (pos),
    .at_last (at_last),
    .low_len (low_len),
    .sda_pos (sda_pos)
  );

  assign tick_fall = iclk_en && (pos == '0);
  assign tick_sda  = iclk_en && (pos == sda_pos);
  assign tick_rise = iclk_en && (pos == low_len);

  // R7: registered line level, idle high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      scl_out <= 1'b1;
    else if (!enable)
      scl_out <= 1'b1;
    else if (tick_fall)
      scl_out <= 1'b0;
    else if (tick_rise)
      scl_out <= 1'b1;
  end

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic tick_fall,
  input logic tick_sda,
  input logic tick_rise,
  input logic scl_out
);

  assert_ticks_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tick_fall, tick_sda, tick_rise}));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !(tick_fall || tick_sda || tick_rise));

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> scl_out);

  assert_fall_from_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |-> scl_out);

  assert_fall_drives_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fall |=> !scl_out);

  assert_rise_drives_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> scl_out);

  assert_rise_from_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |-> !scl_out);

  assert_sda_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_sda |-> !scl_out);

endmodule

bind scl_timing_gen scl_timing_gen_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .tick_fall (tick_fall),
  .tick_sda  (tick_sda),
  .tick_rise (tick_rise),
  .scl_out   (scl_out)
);

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en0 = 1'b0, en1 = 1'b0;
  logic [8:0] cfg0 = '0, cfg1 = '0;
  logic fall0, sda0, rise0, scl0;
  logic fall1, sda1, rise1, scl1;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  scl_timing_gen #(.ICLK_HZ(16_000_000), .CHANNEL(0)) i_scl_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(en0), .timing_cfg(cfg0),
    .tick_fall(fall0), .tick_sda(sda0), .tick_rise(rise0), .scl_out(scl0));

  scl_timing_gen #(.ICLK_HZ(16_000_000), .CHANNEL(1)) i_scl_timing_gen_ch1 (
    .clk(clk), .rst_n(rst_n), .enable(en1), .timing_cfg(cfg1),
    .tick_fall(fall1), .tick_sda(sda1), .tick_rise(rise1), .scl_out(scl1));

  // cdf_a, scgd_a, cdf_b, scgd_b (b is written right after the first fall tick)
  localparam int VEC [6][4] = '{
    '{0, 0, 0, 0},
    '{7, 63, 7, 63},
    '{3, 10, 3, 10},
    '{1, 5, 4, 2},
    '{5, 1, 0, 7},
    '{2, 33, 2, 33}
  };

  function automatic int f_clks(int chan);
    longint ns;
    ns = 235 + ((chan == 0) ? 50 : 5);
    return int'((ns * 16_000_000 + 999_999_999) / 1_000_000_000);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic run_vec(int ca, int sa, int cb, int sb);
    int f1 = -1, s1 = -1, r1 = -1, f2 = -1, r2 = -1;
    int sclf = -1, sclr = -1;
    bit multi = 1'b0;
    int fc, da, db, pa, pb, lowa, lowb;
    fc = f_clks(0);
    da = ca + 1; db = cb + 1;
    pa = 20 + 8 * sa + fc; pb = 20 + 8 * sb + fc;
    lowa = (pa + 1) / 2; lowb = (pb + 1) / 2;
    @(negedge clk);
    en0 = 1'b0;
    cfg0 = {sa[5:0], ca[2:0]};  // R1 field layout
    repeat (3) @(negedge clk);
    en0 = 1'b1;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      #1;
      if ((int'(fall0) + int'(sda0) + int'(rise0)) > 1) multi = 1'b1;
      if (f1 >= 0 && cyc == f1 + 1) sclf = int'(scl0);
      if (r1 >= 0 && cyc == r1 + 1) sclr = int'(scl0);
      if (fall0) begin
        if (f1 < 0) begin
          f1 = cyc;
          cfg0 = {sb[5:0], cb[2:0]};
        end else if (f2 < 0) f2 = cyc;
      end
      if (sda0 && f1 >= 0 && s1 < 0) s1 = cyc;
      if (rise0) begin
        if (f2 >= 0 && r2 < 0) r2 = cyc;
        else if (f1 >= 0 && r1 < 0) r1 = cyc;
      end
      if (r2 >= 0) break;
      @(negedge clk);
    end
    chk(f1 == ca, "R8 first fall delay", f1, ca);
    chk(s1 - f1 == (lowa / 2) * da, "R6 sda point", s1 - f1, (lowa / 2) * da);
    chk(r1 - f1 == lowa * da, "R5 low phase R2", r1 - f1, lowa * da);
    chk(f2 - f1 == (pa - 1) * da + db, "R3 period R9", f2 - f1, (pa - 1) * da + db);
    chk(r2 - f2 == lowb * db, "R9 new cfg low phase", r2 - f2, lowb * db);
    chk(sclf == 0, "R7 low after fall", sclf, 0);
    chk(sclr == 1, "R7 high after rise", sclr, 1);
    chk(!multi, "R10 exclusive ticks", int'(multi), 0);
    @(negedge clk);
    en0 = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // Reset state (R7)
    repeat (3) @(negedge clk);
    #1;
    chk(scl0 == 1'b1, "R7 reset level", int'(scl0), 1);
    chk(!(fall0 || sda0 || rise0), "R8 reset no ticks", int'(fall0 | sda0 | rise0), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Idle: no ticks while disabled (R8)
    begin
      bit seen = 1'b0;
      bit low_seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        #1;
        if (fall0 || sda0 || rise0) seen = 1'b1;
        if (!scl0) low_seen = 1'b1;
      end
      chk(!seen, "R8 idle quiet", int'(seen), 0);
      chk(!low_seen, "R7 idle high", int'(low_seen), 0);
    end

    foreach (VEC[v]) run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // Disable in low phase returns the line high (R7)
    @(negedge clk);
    cfg0 = 9'd0;
    en0 = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(scl0 == 1'b0, "R7 low during phase", int'(scl0), 0);
    @(negedge clk);
    en0 = 1'b0;
    @(negedge clk);
    #1;
    chk(scl0 == 1'b1, "R7 high after disable", int'(scl0), 1);

    // Channel 1 compensation (R11, R4)
    begin
      int fa = -1, ra = -1, fb = -1;
      int p1;
      p1 = 20 + f_clks(1);
      cfg1 = 9'd0;
      @(negedge clk);
      en1 = 1'b1;
      for (int cyc = 0; cyc < 200; cyc++) begin
        #1;
        if (fall1) begin
          if (fa < 0) fa = cyc;
          else if (fb < 0) fb = cyc;
        end
        if (rise1 && ra < 0) ra = cyc;
        if (fb >= 0) break;
        @(negedge clk);
      end
      chk(fb - fa == 24, "R11 channel 1 period", fb - fa, 24);
      chk(fb - fa == p1, "R4 compensation term", fb - fa, p1);
      chk(ra - fa == 12, "R11 channel 1 low phase", ra - fa, 12);
      @(negedge clk);
      en1 = 1'b0;
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule